// File: doc/BRIEF.md
# Merged-Stage Logarithmic Barrel Shifter

This block is a purely combinational shifter for a data word of parameterised width. Its shift amount has log2(WIDTH) bits. The usual design spends one 2:1 selector level per shift bit. Here the shift bits are gathered instead into a chain of stages that each consume one, two or three of them. A two-bit stage is a 4-way selector per output bit, and a three-bit stage is an 8-way selector per output bit. The bits gathered into one stage may sit at any positions in the shift amount, not only neighbouring ones. Removing selector levels in this way shortens the path from a late-arriving shift bit to the output.

The grouping is fixed when the design is elaborated, and it can be set in one of two ways. In the first, the integrator supplies an arrival time for each shift bit and a delay figure for each of the three stage kinds. An elaboration-time function then orders the bits from earliest to latest and builds groups greedily. It takes the three earliest remaining bits and makes a three-bit stage if that finishes sooner than three single stages and also sooner than a two-bit stage plus half a two-bit delay. Otherwise it makes a two-bit stage from the two earliest bits if that beats two single stages. Otherwise it makes a single stage for the earliest bit, and then it repeats. With one or two bits left, only the two-bit and single options are weighed. In the second way, the integrator lists the bit order and the group sizes directly.

A parameter selects the direction. The left-shift build fills the vacated bits at the bottom with zeros, and the right-shift build fills the vacated bits at the top with zeros. WIDTH must be a power of two of at least 8 and at most 256.

Top module: `bshift_merged`

## Requirements
- R1: In the left-shift build, data_out equals data_in shifted left by shamt, truncated to WIDTH bits, for every shamt and every grouping.
- R2: In the left-shift build, output bits below position shamt are 0 regardless of data_in.
- R3: With shamt = 0 the output equals data_in in every build.
- R4: With SHIFT_RIGHT = 1, data_out equals data_in logically shifted right by shamt, and the top shamt output bits are 0.
- R5: With AUTO_PLAN = 1 the grouping comes from the greedy arrival-time rule. For any arrival and delay parameters, the output still satisfies R1.
- R6: A two-bit stage built from shift bits i and j (adjacent or not) applies an offset of 0, 2^i, 2^j or 2^i + 2^j, as selected by those two bits.
- R7: A three-bit stage built from shift bits i, j and k (adjacent or not) applies the sum of the subset of {2^i, 2^j, 2^k} picked by those bits, giving eight possible offsets.
- R8: Every shift bit acts in exactly one stage. A shamt with only bit k set moves the data by exactly 2^k, and no stage creates a 1 that was not present at its input.
- R9: With shamt = WIDTH-1 in the left-shift build, the output holds data_in[0] in its top bit and 0 everywhere else.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | WIDTH | Word to be shifted |
| shamt | input | SHW = log2(WIDTH) | Shift distance, unsigned |
| data_out | output | WIDTH | Shifted word, zero-filled on the vacated side |

## Verification
The bound checker evaluates a set of properties whenever an input changes. It checks the arithmetic result in either direction, the zero fill on the vacated side, the pass-through at a zero shift amount, and that no stage in the chain gains a 1 bit over its input. Some behaviour is visible only by comparing several builds, and the bench's sweeps cover it. That includes the greedy arrival rule producing a different chain with the same function, and non-adjacent bits merged into two- and three-bit stages. It also includes the exact offset applied for each single-bit amount and the maximum shift. The sweeps drive every shift amount against corner and random words on five builds, each grouped differently.

// File: rtl/bshift_pkg.sv
`timescale 1ns/1ps
package bshift_pkg;

    localparam int MAX_SBITS = 8;

    // One entry per stage, in cascade order.
    typedef struct packed {
        logic [3:0]           nstage;
        logic [7:0][1:0]      size;
        logic [7:0][2:0][3:0] bits;
    } plan_t;

    // Stable ascending sort of shift-bit indices by arrival time.
    function automatic logic [7:0][3:0] order_by_arrival(
        input int               sbits,
        input logic [7:0][15:0] arr
    );
        logic [7:0][3:0] ord;
        logic [3:0]      tmp;
        for (int i = 0; i < MAX_SBITS; i++) ord[i] = 4'(i);
        for (int p = 0; p < MAX_SBITS; p++) begin
            for (int q = 1; q < MAX_SBITS; q++) begin
                if (q < sbits && arr[ord[q][2:0]] < arr[ord[q-1][2:0]]) begin
                    tmp      = ord[q];
                    ord[q]   = ord[q-1];
                    ord[q-1] = tmp;
                end
            end
        end
        return ord;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Fill one stage entry from a run of the ordered bit list.
    function automatic plan_t put_stage(
        input plan_t           pl,
        input int              g,
        input logic [7:0][3:0] ord,
        input int              pos,
        input int              take
    );
        plan_t r;
        int    p1;
        int    p2;
        r  = pl;
        p1 = (pos + 1) % MAX_SBITS;
        p2 = (pos + 2) % MAX_SBITS;
        r.size[g[2:0]]    = 2'(take);
        r.bits[g[2:0]][0] = ord[pos[2:0]];
        r.bits[g[2:0]][1] = (take > 1) ? ord[p1[2:0]] : 4'd0;
        r.bits[g[2:0]][2] = (take > 2) ? ord[p2[2:0]] : 4'd0;
        r.nstage          = r.nstage + 4'd1;
        return r;
    endfunction

    // Greedy grouping from arrival times and per-kind stage delays.
    function automatic plan_t plan_from_timing(
        input int               sbits,
        input logic [7:0][15:0] arr,
        input int               d_one,
        input int               d_two,
        input int               d_three
    );
        plan_t           pl;
        logic [7:0][3:0] ord;
        int pos, take, p1, p2;
        int ti, tj, tk, t_s2, t_s3, t_du, t_tr;
        pl  = '0;
        ord = order_by_arrival(sbits, arr);
        pos = 0;
        for (int g = 0; g < MAX_SBITS; g++) begin
            if (pos < sbits) begin
                take = 1;
                p1   = (pos + 1) % MAX_SBITS;
                p2   = (pos + 2) % MAX_SBITS;
                ti   = int'(arr[ord[pos[2:0]][2:0]]);
                t_s2 = 0;
                t_du = 0;
                if (sbits - pos >= 2) begin
                    tj   = int'(arr[ord[p1[2:0]][2:0]]);
                    t_s2 = max2(ti + d_one, tj) + d_one;
                    t_du = max2(ti, tj) + d_two;
                    if (t_du < t_s2) take = 2;
                end
                if (sbits - pos >= 3) begin
                    tk   = int'(arr[ord[p2[2:0]][2:0]]);
                    t_s3 = max2(t_s2, tk) + d_one;
                    t_tr = tk + d_three;
                    if (t_tr < t_s3 && 2 * t_tr < 2 * t_du + d_two) take = 3;
                end
                pl  = put_stage(pl, g, ord, pos, take);
                pos = pos + take;
            end
        end
        return pl;
    endfunction

    // Grouping listed by hand: bit order plus group sizes (0 ends the list).
    function automatic plan_t plan_from_list(
        input int              sbits,
        input logic [7:0][3:0] ord,
        input logic [7:0][1:0] sizes
    );
        plan_t pl;
        int    pos;
        int    take;
        pl  = '0;
        pos = 0;
        for (int g = 0; g < MAX_SBITS; g++) begin
            if (pos < sbits && sizes[g] != 2'd0) begin
                take = int'(sizes[g]);
                pl   = put_stage(pl, g, ord, pos, take);
                pos  = pos + take;
            end
        end
        return pl;
    endfunction

endpackage

// File: rtl/bshift_stage.sv
`timescale 1ns/1ps
// One stage of the chain: NSEL shift bits resolved by a 2^NSEL-way
// selector per output bit. Out-of-range sources are tied to 0.
module bshift_stage #(
    parameter int WIDTH       = 16,
    parameter int NSEL        = 1,
    parameter bit SHIFT_RIGHT = 1'b0,
    parameter int STEP0       = 1,
    parameter int STEP1       = 0,
    parameter int STEP2       = 0
) (
    input  logic [WIDTH-1:0] din,
    input  logic [NSEL-1:0]  sel,
    output logic [WIDTH-1:0] dout
);

    localparam int NWAY = 1 << NSEL;

    function automatic int code_offset(input int code);
        int acc;
        acc = 0;
        if (code[0])             acc = acc + STEP0;
        if (NSEL > 1 && code[1]) acc = acc + STEP1;
        if (NSEL > 2 && code[2]) acc = acc + STEP2;
        return acc;
    endfunction

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [NWAY-1:0] cand;
        for (genvar c = 0; c < NWAY; c++) begin : g_way
            localparam int OFF = code_offset(c);
            localparam int SRC = SHIFT_RIGHT ? (b + OFF) : (b - OFF);
            if (SRC >= 0 && SRC < WIDTH) begin : g_src
                assign cand[c] = din[SRC];
            end else begin : g_zero
                assign cand[c] = 1'b0;
            end
        end
        assign dout[b] = cand[sel];
    end

endmodule

// File: rtl/bshift_merged.sv
`timescale 1ns/1ps
module bshift_merged
    import bshift_pkg::*;
#(
    parameter int               WIDTH        = 16,
    parameter int               SHW          = $clog2(WIDTH),
    parameter bit               SHIFT_RIGHT  = 1'b0,
    parameter bit               AUTO_PLAN    = 1'b1,
    parameter logic [7:0][15:0] ARRIVAL      = '0,
    parameter int               DELAY_SINGLE = 10,
    parameter int               DELAY_DUAL   = 14,
    parameter int               DELAY_TRIPLE = 18,
    parameter logic [7:0][3:0]  MAN_ORDER    = {4'd7, 4'd6, 4'd5, 4'd4, 4'd3, 4'd2, 4'd1, 4'd0},
    parameter logic [7:0][1:0]  MAN_SIZE     = {8{2'd1}}
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic [SHW-1:0]   shamt,
    output logic [WIDTH-1:0] data_out
);

    localparam plan_t PLAN = AUTO_PLAN
        ? plan_from_timing(SHW, ARRIVAL, DELAY_SINGLE, DELAY_DUAL, DELAY_TRIPLE)
        : plan_from_list(SHW, MAN_ORDER, MAN_SIZE);
    localparam int NSTAGE = int'(PLAN.nstage);

    // chain[0] is the input word, chain[NSTAGE] the result.
    logic [NSTAGE:0][WIDTH-1:0] chain;

    assign chain[0] = data_in;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        localparam int SZ = int'(PLAN.size[g]);
        localparam int B0 = int'(PLAN.bits[g][0]);
        localparam int B1 = (SZ > 1) ? int'(PLAN.bits[g][1]) : 0;
        localparam int B2 = (SZ > 2) ? int'(PLAN.bits[g][2]) : 0;

        logic [SZ-1:0] sel_d;
        for (genvar m = 0; m < SZ; m++) begin : g_sel
            assign sel_d[m] = shamt[int'(PLAN.bits[g][m])];
        end

        bshift_stage #(
            .WIDTH      (WIDTH),
            .NSEL       (SZ),
            .SHIFT_RIGHT(SHIFT_RIGHT),
            .STEP0      (1 << B0),
            .STEP1      ((SZ > 1) ? (1 << B1) : 0),
            .STEP2      ((SZ > 2) ? (1 << B2) : 0)
        ) u_stage (
            .din (chain[g]),
            .sel (sel_d),
            .dout(chain[g+1])
        );
    end

    assign data_out = chain[NSTAGE];

endmodule

// File: rtl/bshift_merged_chk.sv
`timescale 1ns/1ps
module bshift_merged_chk #(
    parameter int WIDTH       = 16,
    parameter int SHW         = 4,
    parameter int NSTAGE      = 1,
    parameter bit SHIFT_RIGHT = 1'b0
) (
    input logic [WIDTH-1:0]             data_in,
    input logic [SHW-1:0]               shamt,
    input logic [WIDTH-1:0]             data_out,
    input logic [NSTAGE:0][WIDTH-1:0]   chain
);

    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    always_comb begin
        if (!$isunknown({data_in, shamt})) begin
            // R1: left result is the arithmetic shift
            assert_left_result_R1: assert (SHIFT_RIGHT || data_out == (data_in << shamt));
            // R4: right result is the logical right shift
            assert_right_result_R4: assert (!SHIFT_RIGHT || data_out == (data_in >> shamt));
            // R2: vacated side holds zeros
            assert_fill_zero_R2: assert (SHIFT_RIGHT
                ? ((data_out & ~(ALL_ONES >> shamt)) == '0)
                : ((data_out & ~(ALL_ONES << shamt)) == '0));
            // R3: zero amount passes the word through
            assert_zero_amount_R3: assert (shamt != '0 || data_out == data_in);
            // R8: no stage of the chain creates a set bit
            for (int g = 0; g < NSTAGE; g++) begin
                assert_stage_no_new_ones_R8: assert ($countones(chain[g+1]) <= $countones(chain[g]));
            end
        end
    end

endmodule

bind bshift_merged bshift_merged_chk #(
    .WIDTH      (WIDTH),
    .SHW        (SHW),
    .NSTAGE     (NSTAGE),
    .SHIFT_RIGHT(SHIFT_RIGHT)
) u_chk (
    .data_in (data_in),
    .shamt   (shamt),
    .data_out(data_out),
    .chain   (chain)
);

// File: tb/bshift_merged_test.sv
`timescale 1ns/1ps
module bshift_merged_test;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    int  n_checks = 0;
    int  n_err    = 0;
    bit  done     = 1'b0;

    logic [7:0]  d8;
    logic [2:0]  s8;
    logic [7:0]  o8;
    logic [15:0] d16;
    logic [3:0]  s4;
    logic [15:0] o16a;
    logic [15:0] o16r;
    logic [15:0] o16s;
    logic [31:0] d32;
    logic [4:0]  s5;
    logic [31:0] o32;

    // Auto grouping, equal arrivals: three-bit stage {0,1,2} then single {3}.
    bshift_merged #(.WIDTH(16)) uut (
        .data_in(d16), .shamt(s4), .data_out(o16a));

    // Two-bit stage of non-adjacent bits {0,2}, then single {1}.
    bshift_merged #(
        .WIDTH(8), .AUTO_PLAN(1'b0),
        .MAN_ORDER({4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd1, 4'd2, 4'd0}),
        .MAN_SIZE ({2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd2})
    ) u_w8_dual (.data_in(d8), .shamt(s8), .data_out(o8));

    // Two-bit stage {3,0}, then three-bit stage {4,1,2}.
    bshift_merged #(
        .WIDTH(32), .AUTO_PLAN(1'b0),
        .MAN_ORDER({4'd0, 4'd0, 4'd0, 4'd2, 4'd1, 4'd4, 4'd0, 4'd3}),
        .MAN_SIZE ({2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd3, 2'd2})
    ) u_w32_mix (.data_in(d32), .shamt(s5), .data_out(o32));

    // Right shift, one stage per bit.
    bshift_merged #(.WIDTH(16), .SHIFT_RIGHT(1'b1), .AUTO_PLAN(1'b0)) u_w16_right (
        .data_in(d16), .shamt(s4), .data_out(o16r));

    // Staggered arrivals: single {0}, then three-bit stage {1,2,3}.
    bshift_merged #(
        .WIDTH(16),
        .ARRIVAL({16'd0, 16'd0, 16'd0, 16'd0, 16'd44, 16'd42, 16'd40, 16'd0})
    ) u_w16_stagger (.data_in(d16), .shamt(s4), .data_out(o16s));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string tag16(input logic [3:0] s);
        if (s == 4'd0)  return "R3 zero amount";
        if (s == 4'd15) return "R9 maximum amount";
        if ($onehot(s)) return "R8 single-bit amount";
        return "R1 left shift";
    endfunction

    function automatic logic [31:0] pattern(input int n);
        case (n)
            0:       return 32'hFFFF_FFFF;
            1:       return 32'h0000_0001;
            2:       return 32'h8000_8080;
            3:       return 32'hA5A5_A5A5;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        logic [31:0] p;
        logic [15:0] e16;
        d8 = '0; s8 = '0; d16 = '0; s4 = '0; d32 = '0; s5 = '0;
        @(negedge clk);
        check("R1 idle zero word", {16'h0, o16a}, 32'h0);
        check("R4 idle zero word", {16'h0, o16r}, 32'h0);
        check("R6 idle zero word", {24'h0, o8}, 32'h0);
        for (int s = 0; s < 32; s++) begin
            for (int n = 0; n < 12; n++) begin
                @(posedge clk);
                p   = pattern(n);
                d8  = p[7:0];
                d16 = p[15:0];
                d32 = p;
                s8  = 3'(s);
                s4  = 4'(s);
                s5  = 5'(s);
                @(negedge clk);
                e16 = d16 << s4;
                check(tag16(s4), {16'h0, o16a}, {16'h0, e16});
                check("R2 low fill", {16'h0, o16a & ~(16'hFFFF << s4)}, 32'h0);
                check("R5 arrival-driven grouping", {16'h0, o16s}, {16'h0, e16});
                check("R6 two-bit non-adjacent stage", {24'h0, o8}, {24'h0, d8 << s8});
                check("R7 three-bit non-adjacent stage", o32, d32 << s5);
                check("R4 right shift", {16'h0, o16r}, {16'h0, d16 >> s4});
                check("R4 high fill", {16'h0, o16r & ~(16'hFFFF >> s4)}, 32'h0);
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule